// File: doc/BRIEF.md
# Generation-Phase Egress Descriptor Ring Consumer

This block reads egress transfer descriptors from a ring of power-of-two size. The ring is held in an internal descriptor store, and software fills that store through a single write port. A descriptor is 128 bits wide. The low 64 bits are the control word and the high 64 bits are the buffer word. The block tracks a head slot and an expected generation phase. A slot counts as filled only while its generation bit equals that phase. The producer inverts the generation value it writes on every pass round the ring, so the consumer inverts its expected phase each time the head wraps. No shared producer index and no doorbell are needed.

For each filled slot, the block decodes the fields and then takes one of two paths. If the descriptor moves data, the block presents one transfer command on a valid/ready interface. The command carries the sign-extended address, the byte count, the packet-end flag, the checksum controls and the buffer controls. If the descriptor moves no data, the block retires it at once. When a descriptor retires, the block can raise a one-cycle notification pulse and a one-cycle buffer-return pulse. The return pulse names the stack index and whether the buffer belongs to the other instance. Moving the payload, walking chained buffers and managing the buffer stacks are done elsewhere.

Top module: `edr_consumer`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_valid`, `notify_o` and `rel_valid` are low. The head starts at slot 0 and the expected phase starts at 1.
- R2: A slot is consumed only when bit 0 of its control word equals the expected phase. On a mismatch the block holds at that slot, re-reads it every cycle, and consumes it once the slot is rewritten with the matching value.
- R3: After slot DEPTH-1 is consumed, the head returns to 0 and the expected phase inverts. A slot still carrying the previous pass's generation value is not consumed.
- R4: A command is issued only when the no-send flag (bit 9) is clear and the byte count (bits 29:16) is nonzero. The command carries the following fields:
  - count: bits 29:16
  - packet end: bit 11
  - checksum enable: bit 8
  - checksum start: bits 47:40
  - checksum destination: bits 39:32
  - checksum seed: bits 63:48
  - hardware-buffer flag: bit 122
  - stack index: bits 116:112
  - size code: bits 125:123
  - chain mode: bits 127:126
- R5: The command address is bits 105:64, sign-extended from bit 105 to ADDR_W bits.
- R6: A presented command keeps every field stable until `cmd_ready` is high. In the cycle after acceptance `cmd_valid` is low, so each descriptor yields at most one command.
- R7: A descriptor with the notify bit (bit 10) set produces exactly one `notify_o` pulse. The pulse comes in the cycle after the command is accepted, or in the cycle after the descriptor is consumed if it issues no command.
- R8: A buffer return is raised only when the hardware-buffer flag (bit 122) is set and the byte count is nonzero. A zero count or a clear flag raises none. The pulse follows the same timing as in R7. It carries the sign-extended address, the stack index from bits 116:112, and `rel_remote` set when bit 120 differs from INSTANCE.
- R9: A descriptor with the no-send flag set issues no command, yet still raises its buffer return and notification as in R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Descriptor store write strobe |
| wr_idx | input | AW | Slot written |
| wr_data | input | 128 | Descriptor written |
| cmd_valid | output | 1 | Transfer command presented |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_addr | output | ADDR_W | Sign-extended buffer address |
| cmd_len | output | 14 | Byte count |
| cmd_eop | output | 1 | Descriptor ends the packet |
| cmd_csum_en | output | 1 | Checksum insertion enabled |
| cmd_csum_start | output | 8 | Checksum start offset |
| cmd_csum_dest | output | 8 | Checksum destination offset |
| cmd_csum_seed | output | 16 | Checksum seed |
| cmd_hwb | output | 1 | Buffer is owned by hardware |
| cmd_stack | output | 5 | Buffer stack index |
| cmd_bsize | output | 3 | Buffer size code |
| cmd_chain | output | 2 | Chain mode |
| notify_o | output | 1 | Completion notification pulse |
| rel_valid | output | 1 | Buffer return pulse |
| rel_addr | output | ADDR_W | Returned buffer address |
| rel_stack | output | 5 | Stack receiving the buffer |
| rel_remote | output | 1 | Buffer belongs to the other instance |

## Verification
The bench keeps its own ring image, head and phase, and predicts each output on every clock. It attacks the following corner cases:

- **Stale slot at reset.** A slot written with generation 0 straight after reset must be ignored. A block that starts in the wrong phase would consume it.
- **Stale slot after wrap.** A slot left from the previous pass must be ignored after the head wraps. A block that never inverts its phase would replay the whole ring.
- **Records that move no data.** Zero-count and no-send records must yield no command, yet a no-send record must still return its buffer and notify. A block that gates these on the command would lose buffers or notifications.
- **Held command.** A command held under backpressure must not change or repeat. A block that slips here would corrupt or duplicate a transfer.
- **Negative address.** A negative virtual address must be sign-extended. A block that zero-fills would hand out a wrong address.

// File: rtl/edr_pkg.sv
package edr_pkg;
   localparam int DESC_W   = 128;
   localparam int LEN_W    = 14;
   localparam int VA_W     = 42;
   localparam int STK_W    = 5;
   localparam int BSZ_W    = 3;
   localparam int CHN_W    = 2;
   localparam int OFS_W    = 8;
   localparam int SEED_W   = 16;
   localparam int BUF_BASE = 64;   // first bit of the buffer word

   typedef struct packed {
      logic              gen;
      logic              csum_en;
      logic              no_send;
      logic              notify;
      logic              eop;
      logic [LEN_W-1:0]  len;
      logic [OFS_W-1:0]  cs_dest;
      logic [OFS_W-1:0]  cs_start;
      logic [SEED_W-1:0] cs_seed;
      logic [STK_W-1:0]  stack;
      logic              inst;
      logic              hwb;
      logic [BSZ_W-1:0]  bsize;
      logic [CHN_W-1:0]  chain;
   } edr_desc_t;
endpackage

// File: rtl/edr_desc_ram.sv
module edr_desc_ram #(
   parameter int DEPTH = 16,
   parameter int W     = 128,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] rd_idx,
   output logic [W-1:0]  rd_data
);
   // Generation bits live in reset flops so that no slot looks filled after reset.
   logic [DEPTH-1:0] gen_q;
   logic [W-1:1]     body_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gen_q <= '0;
      else if (wr_en) gen_q[wr_idx] <= wr_data[0];
   end

   always_ff @(posedge clk) begin
      if (wr_en) body_q[wr_idx] <= wr_data[W-1:1];
   end

   assign rd_data = {body_q[rd_idx], gen_q[rd_idx]};
endmodule

// File: rtl/edr_decode.sv
module edr_decode
   import edr_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [DESC_W-1:0] word,
   output edr_desc_t         fld,
   output logic [ADDR_W-1:0] addr
);
   localparam int VA_MSB = BUF_BASE + VA_W - 1;

   assign fld.gen      = word[0];
   assign fld.csum_en  = word[8];
   assign fld.no_send  = word[9];
   assign fld.notify   = word[10];
   assign fld.eop      = word[11];
   assign fld.len      = word[29:16];
   assign fld.cs_dest  = word[39:32];
   assign fld.cs_start = word[47:40];
   assign fld.cs_seed  = word[63:48];
   assign fld.stack    = word[BUF_BASE+52:BUF_BASE+48];
   assign fld.inst     = word[BUF_BASE+56];
   assign fld.hwb      = word[BUF_BASE+58];
   assign fld.bsize    = word[BUF_BASE+61:BUF_BASE+59];
   assign fld.chain    = word[BUF_BASE+63:BUF_BASE+62];

   generate
      if (ADDR_W > VA_W) begin : g_sext
         assign addr = {{(ADDR_W-VA_W){word[VA_MSB]}}, word[VA_MSB:BUF_BASE]};
      end else if (ADDR_W == VA_W) begin : g_exact
         assign addr = word[VA_MSB:BUF_BASE];
      end else begin : g_bad
         $error("edr_decode: ADDR_W narrower than the address field");
      end
   endgenerate

   logic unused_rsvd;
   assign unused_rsvd = ^{word[7:1], word[15:12], word[31:30],
                          word[BUF_BASE+47:BUF_BASE+42], word[BUF_BASE+55:BUF_BASE+53],
                          word[BUF_BASE+57]};
endmodule

// File: rtl/edr_head_trk.sv
module edr_head_trk #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] head,
   output logic          phase
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         phase <= 1'b1;
      end else if (adv) begin
         if (head == LAST) begin
            head  <= '0;
            phase <= ~phase;
         end else begin
            head <= head + 1'b1;
         end
      end
   end
endmodule

// File: rtl/edr_consumer.sv
module edr_consumer
   import edr_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 64,
   parameter bit INSTANCE = 1'b0,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_idx,
   input  logic [DESC_W-1:0] wr_data,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [LEN_W-1:0]  cmd_len,
   output logic              cmd_eop,
   output logic              cmd_csum_en,
   output logic [OFS_W-1:0]  cmd_csum_start,
   output logic [OFS_W-1:0]  cmd_csum_dest,
   output logic [SEED_W-1:0] cmd_csum_seed,
   output logic              cmd_hwb,
   output logic [STK_W-1:0]  cmd_stack,
   output logic [BSZ_W-1:0]  cmd_bsize,
   output logic [CHN_W-1:0]  cmd_chain,
   output logic              notify_o,
   output logic              rel_valid,
   output logic [ADDR_W-1:0] rel_addr,
   output logic [STK_W-1:0]  rel_stack,
   output logic              rel_remote
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_chk
         $error("edr_consumer: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DESC_W-1:0] slot_word;
   edr_desc_t         fld;
   logic [ADDR_W-1:0] slot_addr;
   logic [AW-1:0]     head;
   logic              phase;
   logic              slot_ok, adv, moves, gives, accept;

   logic              busy_q, notif_q, rel_q;
   edr_desc_t         cur_q;
   logic [ADDR_W-1:0] addr_q;

   edr_desc_ram #(.DEPTH(DEPTH), .W(DESC_W), .AW(AW)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (head),
      .rd_data (slot_word)
   );

   edr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .word (slot_word),
      .fld  (fld),
      .addr (slot_addr)
   );

   edr_head_trk #(.DEPTH(DEPTH), .AW(AW)) u_head (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .head  (head),
      .phase (phase)
   );

   assign slot_ok = (fld.gen == phase);
   assign adv     = slot_ok && !busy_q;
   assign moves   = !fld.no_send && (fld.len != '0);
   assign gives   = fld.hwb && (fld.len != '0);
   assign accept  = busy_q && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         notif_q <= 1'b0;
         rel_q   <= 1'b0;
         cur_q   <= '0;
         addr_q  <= '0;
      end else begin
         notif_q <= 1'b0;
         rel_q   <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b0;
            notif_q <= cur_q.notify;
            rel_q   <= cur_q.hwb && (cur_q.len != '0);
         end
         if (adv) begin
            cur_q  <= fld;
            addr_q <= slot_addr;
            if (moves) begin
               busy_q <= 1'b1;
            end else begin
               notif_q <= fld.notify;
               rel_q   <= gives;
            end
         end
      end
   end

   assign cmd_valid      = busy_q;
   assign cmd_addr       = addr_q;
   assign cmd_len        = cur_q.len;
   assign cmd_eop        = cur_q.eop;
   assign cmd_csum_en    = cur_q.csum_en;
   assign cmd_csum_start = cur_q.cs_start;
   assign cmd_csum_dest  = cur_q.cs_dest;
   assign cmd_csum_seed  = cur_q.cs_seed;
   assign cmd_hwb        = cur_q.hwb;
   assign cmd_stack      = cur_q.stack;
   assign cmd_bsize      = cur_q.bsize;
   assign cmd_chain      = cur_q.chain;

   assign notify_o   = notif_q;
   assign rel_valid  = rel_q;
   assign rel_addr   = addr_q;
   assign rel_stack  = cur_q.stack;
   assign rel_remote = (cur_q.inst != INSTANCE);

   logic unused_cur;
   assign unused_cur = cur_q.gen ^ cur_q.no_send;
endmodule

// File: rtl/edr_consumer_chk.sv
module edr_consumer_chk #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [13:0]       cmd_len,
   input logic              cmd_eop,
   input logic              notify_o,
   input logic              rel_valid,
   input logic [AW-1:0]     head,
   input logic              phase,
   input logic              slot_ok,
   input logic              adv
);
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!cmd_valid && !notify_o && !rel_valid));

   a_r2_stall_on_stale: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_ok |=> $stable(head));

   a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && head == AW'(DEPTH - 1)) |=> (phase != $past(phase)));

   a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_len != '0));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=>
         (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_eop)));

   a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_valid);
endmodule

bind edr_consumer edr_consumer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_addr  (cmd_addr),
   .cmd_len   (cmd_len),
   .cmd_eop   (cmd_eop),
   .notify_o  (notify_o),
   .rel_valid (rel_valid),
   .head      (head),
   .phase     (phase),
   .slot_ok   (slot_ok),
   .adv       (adv)
);

// File: tb/edr_consumer_tb.sv
module edr_consumer_tb;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_idx = '0;
   logic [127:0]  wr_data = '0;
   logic          cmd_ready = 1'b0;
   logic          cmd_valid, cmd_eop, cmd_csum_en, cmd_hwb, notify_o, rel_valid, rel_remote;
   logic [63:0]   cmd_addr, rel_addr;
   logic [13:0]   cmd_len;
   logic [7:0]    cmd_csum_start, cmd_csum_dest;
   logic [15:0]   cmd_csum_seed;
   logic [4:0]    cmd_stack, rel_stack;
   logic [2:0]    cmd_bsize;
   logic [1:0]    cmd_chain;

   edr_consumer #(.DEPTH(DEPTH), .ADDR_W(64), .INSTANCE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .cmd_eop(cmd_eop), .cmd_csum_en(cmd_csum_en), .cmd_csum_start(cmd_csum_start),
      .cmd_csum_dest(cmd_csum_dest), .cmd_csum_seed(cmd_csum_seed), .cmd_hwb(cmd_hwb),
      .cmd_stack(cmd_stack), .cmd_bsize(cmd_bsize), .cmd_chain(cmd_chain),
      .notify_o(notify_o), .rel_valid(rel_valid), .rel_addr(rel_addr),
      .rel_stack(rel_stack), .rel_remote(rel_remote)
   );

   int errs = 0, checks = 0;
   int cnt_cmd = 0, cnt_notif = 0, cnt_rel = 0;
   int exp_cmd = 0, exp_notif = 0, exp_rel = 0;
   int rdy_mode = 0;            // 0 always ready, 1 pseudo-random, 2 never ready
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [127:0] m_mem [DEPTH];
   int           m_head;
   bit           m_phase, m_valid, m_notif, m_rel;
   logic [127:0] m_cur;
   bit           was_busy, take;

   function automatic bit moves_data(input logic [127:0] w);
      return !w[9] && (w[29:16] != 14'd0);
   endfunction
   function automatic bit gives_back(input logic [127:0] w);
      return w[122] && (w[29:16] != 14'd0);
   endfunction
   function automatic logic [63:0] sext(input logic [127:0] w);
      return {{22{w[105]}}, w[105:64]};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_head = 0; m_phase = 1'b1; m_valid = 1'b0; m_notif = 1'b0; m_rel = 1'b0;
         m_cur = '0;
         for (int i = 0; i < DEPTH; i++) m_mem[i][0] = 1'b0;
      end else begin
         was_busy = m_valid;
         m_notif = 1'b0;
         m_rel   = 1'b0;
         if (m_valid && cmd_ready) begin
            m_valid = 1'b0;
            m_notif = m_cur[10];
            m_rel   = gives_back(m_cur);
         end
         take = (m_mem[m_head][0] === m_phase) && !was_busy;
         if (take) begin
            m_cur = m_mem[m_head];
            if (moves_data(m_cur)) m_valid = 1'b1;
            else begin
               m_notif = m_cur[10];
               m_rel   = gives_back(m_cur);
            end
            if (m_head == DEPTH - 1) begin m_head = 0; m_phase = ~m_phase; end
            else m_head = m_head + 1;
         end
         if (wr_en) m_mem[wr_idx] = wr_data;
      end
   end

   // ---------------- per-cycle comparison, ready drive, tallies ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cmd_valid === m_valid, "R6 cmd_valid", 128'(cmd_valid), 128'(m_valid));
         if (m_valid) begin
            chk({cmd_len, cmd_eop, cmd_csum_en, cmd_csum_start, cmd_csum_dest, cmd_csum_seed,
                 cmd_hwb, cmd_stack, cmd_bsize, cmd_chain} ===
                {m_cur[29:16], m_cur[11], m_cur[8], m_cur[47:40], m_cur[39:32], m_cur[63:48],
                 m_cur[122], m_cur[116:112], m_cur[125:123], m_cur[127:126]},
                "R4 command fields",
                128'({cmd_len, cmd_eop, cmd_csum_en, cmd_csum_start, cmd_csum_dest, cmd_csum_seed,
                      cmd_hwb, cmd_stack, cmd_bsize, cmd_chain}),
                128'({m_cur[29:16], m_cur[11], m_cur[8], m_cur[47:40], m_cur[39:32], m_cur[63:48],
                      m_cur[122], m_cur[116:112], m_cur[125:123], m_cur[127:126]}));
            chk(cmd_addr === sext(m_cur), "R5 command address", 128'(cmd_addr), 128'(sext(m_cur)));
         end
         chk(notify_o === m_notif, "R7 notify pulse", 128'(notify_o), 128'(m_notif));
         chk(rel_valid === m_rel, "R8 release pulse", 128'(rel_valid), 128'(m_rel));
         if (m_rel)
            chk({rel_addr, rel_stack, rel_remote} === {sext(m_cur), m_cur[116:112], m_cur[120]},
                "R8 release fields", 128'({rel_addr, rel_stack, rel_remote}),
                128'({sext(m_cur), m_cur[116:112], m_cur[120]}));
         if (notify_o) cnt_notif++;
         if (rel_valid) cnt_rel++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
      if (rst_n && cmd_valid && cmd_ready) cnt_cmd++;
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [127:0] mk(input bit g, input int len, input bit ns, input bit nt,
                                       input bit eop, input bit cs, input logic [7:0] st,
                                       input logic [7:0] ds, input logic [15:0] sd,
                                       input logic [41:0] va, input logic [4:0] stk,
                                       input bit inst, input bit hwb, input logic [2:0] bsz,
                                       input logic [1:0] ch);
      logic [127:0] w = '0;
      w[0] = g; w[8] = cs; w[9] = ns; w[10] = nt; w[11] = eop;
      w[29:16] = 14'(len); w[39:32] = ds; w[47:40] = st; w[63:48] = sd;
      w[105:64] = va; w[116:112] = stk; w[120] = inst; w[122] = hwb;
      w[125:123] = bsz; w[127:126] = ch;
      return w;
   endfunction

   task automatic put(input int idx, input logic [127:0] w, input bit live);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = AW'(idx); wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
      if (live) begin
         exp_cmd   += moves_data(w);
         exp_notif += w[10];
         exp_rel   += gives_back(w);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tallies(input string tag);
      chk(cnt_cmd == exp_cmd, {tag, " command count"}, 128'(cnt_cmd), 128'(exp_cmd));
      chk(cnt_notif == exp_notif, {tag, " notify count"}, 128'(cnt_notif), 128'(exp_notif));
      chk(cnt_rel == exp_rel, {tag, " release count"}, 128'(cnt_rel), 128'(exp_rel));
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: idle outputs while in reset
      repeat (3) @(negedge clk);
      chk({cmd_valid, notify_o, rel_valid} === 3'b000, "R1 outputs in reset",
          128'({cmd_valid, notify_o, rel_valid}), 128'(0));
      rst_n = 1'b1;
      idle(2);
      chk({cmd_valid, notify_o, rel_valid} === 3'b000, "R1 outputs after reset",
          128'({cmd_valid, notify_o, rel_valid}), 128'(0));

      // R2: a slot with generation 0 is stale in the first pass
      put(0, mk(1'b0, 64, 0, 1, 1, 0, 8'd0, 8'd0, 16'd0, 42'h123, 5'd1, 0, 1, 3'd1, 2'd0), 1'b0);
      idle(8);
      chk(cnt_cmd == 0 && !cmd_valid, "R2 stale slot not consumed", 128'(cnt_cmd), 128'(0));
      // R2/R5: rewritten with the matching phase, negative address
      put(0, mk(1'b1, 64, 0, 1, 1, 1, 8'd14, 8'd10, 16'hBEEF, {1'b1, 41'h0_0000_1000},
                5'd3, 0, 1, 3'd2, 2'd1), 1'b1);
      idle(6);
      tallies("R2");

      // R4/R7/R8/R9: rest of the first pass under random backpressure
      rdy_mode = 1;
      for (int i = 1; i < DEPTH; i++) begin
         put(i, mk(1'b1, (i % 4 == 0) ? 0 : 16 * i, (i % 5 == 2), (i % 3 == 0), (i % 4 == 1),
                   i[0], 8'(i), 8'(i + 2), 16'(i * 257), {i[0], 41'(i * 4096)}, 5'(i),
                   (i % 4 == 3), i[0], 3'(i), 2'(i)), 1'b1);
      end
      idle(80);
      tallies("R4 first pass");

      // R3: after the wrap, slot 0 still holds generation 1 and is stale
      rdy_mode = 0;
      idle(8);
      chk(cnt_cmd == exp_cmd && !cmd_valid, "R3 stale slot after wrap",
          128'(cnt_cmd), 128'(exp_cmd));
      put(0, mk(1'b0, 40, 0, 0, 1, 0, 8'd0, 8'd0, 16'd0, 42'h40, 5'd2, 0, 0, 3'd0, 2'd0), 1'b1);
      idle(6);
      tallies("R3 second pass");

      // R9: no-send with a hardware buffer still returns and notifies
      put(1, mk(1'b0, 8, 1, 1, 1, 0, 8'd0, 8'd0, 16'd0, {1'b1, 41'h55}, 5'd9, 1, 1, 3'd3, 2'd0), 1'b1);
      idle(4);
      tallies("R9");

      // R8: zero byte count suppresses the return even with the buffer flag
      put(2, mk(1'b0, 0, 0, 0, 0, 0, 8'd0, 8'd0, 16'd0, 42'h77, 5'd4, 0, 1, 3'd0, 2'd0), 1'b1);
      idle(4);
      tallies("R8 zero count");

      // R6: command held under backpressure
      rdy_mode = 2;
      put(3, mk(1'b0, 200, 0, 1, 1, 1, 8'd4, 8'd6, 16'h1234, 42'h3FF_0000_0000, 5'd7, 0, 1,
                3'd4, 2'd2), 1'b1);
      idle(10);
      chk(cmd_valid === 1'b1 && cmd_len == 14'd200, "R6 command held",
          128'({cmd_valid, cmd_len}), 128'({1'b1, 14'd200}));
      chk(cnt_cmd == exp_cmd - 1, "R6 not yet accepted", 128'(cnt_cmd), 128'(exp_cmd - 1));
      rdy_mode = 0;
      idle(4);
      tallies("R6 after release");

      finish_run();
   end
endmodule